// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the control sequencer of a small accumulator machine whose 40-bit memory word carries two 20-bit instructions. Each instruction is an 8-bit opcode followed by a 12-bit address. The sequencer reads a word once, runs the upper (left) instruction, and keeps the lower (right) instruction in an instruction buffer. It then runs that buffered instruction without touching memory again. The program counter advances once per word.

The block holds the program counter, instruction register, memory address and buffer registers, the instruction buffer with its pending flag, and the accumulator. It executes load, add, store, unconditional jump and halt. It drives a synchronous word RAM that has one cycle of read latency. The RAM port is a fixed-latency strobe interface with no back-pressure. A read strobe always returns its data on the following cycle, and a write strobe always completes in its own cycle. The block runs from address 0 as soon as reset is released, and it stops for good in a halted state.

Top module: `pair_fetch_seq`

## Requirements
- R1: While reset is held and after its release, `pc_out` = 0, `acc_out` = 0 and `halted` = 0. The first memory access after release is a read of address 0.
- R2: A word is split as follows: the left instruction is bits 39:20 (opcode 39:32, address 31:20) and the right instruction is bits 19:0 (opcode 19:12, address 11:0). The left instruction executes before the right one.
- R3: The right instruction executes from the buffer. Running a word of two non-jump instructions costs exactly one fetch read, plus one read per load or add operand.
- R4: The program counter advances by one per fetched word and wraps from 999 to 0. It always stays below 1000.
- R5: Opcode 0x01 (load) sets the accumulator to the memory word at the instruction address.
- R6: Opcode 0x05 (add) sets the accumulator to the accumulator plus the memory word at the address, modulo 2^40.
- R7: Opcode 0x21 (store) writes the accumulator to memory at the instruction address.
- R8: Opcode 0x0D (jump) loads the program counter with the address and discards a pending right instruction. The next instruction comes from a fresh fetch of the target word.
- R9: Opcode 0x00 and every opcode other than 0x01, 0x05, 0x21 and 0x0D halt the sequencer. Once halted, `halted` stays 1 until reset, and no further read or write is issued.
- R10: A load, add, store or jump whose address is 1000 or above halts the sequencer without any memory access. The accumulator is left unchanged.
- R11: A read and a write are never issued in the same cycle, and a read is never issued in the cycle right after another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address for the RAM (the memory address register) |
| mem_rd | output | 1 | Read strobe; data is due on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 40 | Write data (the memory buffer register) |
| mem_rdata | input | 40 | Read data from the RAM, one cycle after `mem_rd` |
| halted | output | 1 | High once a halt condition has been reached |
| pc_out | output | 12 | Current program counter |
| acc_out | output | 40 | Current accumulator |

## Verification
The memory model returns read data one cycle after each strobe and commits writes on the strobe edge, which is the latency the sequencer assumes. A word with a load and a store takes roughly a dozen cycles, so each scenario runs until `halted` rises, with a cycle limit. The bench then compares the accumulator, the program counter, the touched memory words and the read and write counts against values computed from the program. All outputs are sampled on the falling edge, half a period after the edge that updates them. Rule R11 is checked in every cycle by counters in the memory model.

// File: rtl/pair_seq_pkg.sv
`timescale 1ns/1ps
package pair_seq_pkg;
  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h05;
  localparam logic [7:0] OPC_STORE = 8'h21;
  localparam logic [7:0] OPC_JUMP  = 8'h0D;

  typedef enum logic [2:0] {
    K_LOAD, K_ADD, K_STORE, K_JUMP, K_HALT
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_FETCH_A, ST_FETCH_R, ST_FETCH_W, ST_SPLIT,
    ST_EXEC, ST_OP_W, ST_OP_X, ST_ST_W, ST_NEXT, ST_HALT
  } seq_state_e;
endpackage

// File: rtl/insn_fields.sv
`timescale 1ns/1ps
module insn_fields #(
  parameter int OPC_W = 8,
  parameter int ADR_W = 12,
  localparam int INSN_W = OPC_W + ADR_W
) (
  input  logic [INSN_W-1:0] insn,
  output logic [OPC_W-1:0]  opc,
  output logic [ADR_W-1:0]  adr
);
  // opcode sits in the upper part of each instruction
  assign opc = insn[INSN_W-1 -: OPC_W];
  assign adr = insn[ADR_W-1:0];
endmodule

// File: rtl/opcode_decode.sv
`timescale 1ns/1ps
module opcode_decode
  import pair_seq_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opc,
  output op_kind_e         kind
);
  always_comb begin
    if (opc == OPC_W'(OPC_LOAD))       kind = K_LOAD;
    else if (opc == OPC_W'(OPC_ADD))   kind = K_ADD;
    else if (opc == OPC_W'(OPC_STORE)) kind = K_STORE;
    else if (opc == OPC_W'(OPC_JUMP))  kind = K_JUMP;
    else                               kind = K_HALT; // halt and all unknown codes
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu #(
  parameter int DATA_W = 40
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  logic              add_en,
  output logic [DATA_W-1:0] result
);
  // sum wraps modulo 2^DATA_W, carry out is dropped
  assign result = add_en ? (acc + operand) : operand;
endmodule

// File: rtl/pair_fetch_seq.sv
`timescale 1ns/1ps
module pair_fetch_seq
  import pair_seq_pkg::*;
#(
  parameter int OPC_W      = 8,
  parameter int ADR_W      = 12,
  parameter int ADDR_LIMIT = 1000,
  parameter int RESET_PC   = 0,
  localparam int INSN_W = OPC_W + ADR_W,
  localparam int DATA_W = 2 * INSN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADR_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADR_W-1:0]  pc_out,
  output logic [DATA_W-1:0] acc_out
);
  localparam logic [ADR_W-1:0] LAST_ADR = ADR_W'(ADDR_LIMIT - 1);
  localparam logic [ADR_W-1:0] LIM_ADR  = ADR_W'(ADDR_LIMIT);

  seq_state_e          state;
  logic [ADR_W-1:0]    pc, mar;
  logic [DATA_W-1:0]   mbr, acc;
  logic [OPC_W-1:0]    ir;
  logic [INSN_W-1:0]   ibr;
  logic                ibr_full;

  logic [OPC_W-1:0]    left_opc, buf_opc;
  logic [ADR_W-1:0]    left_adr, buf_adr, pc_next;
  logic [DATA_W-1:0]   alu_out;
  op_kind_e            kind;
  logic                addr_ok, op_read;

  insn_fields #(.OPC_W(OPC_W), .ADR_W(ADR_W)) i_left (
    .insn(mbr[DATA_W-1 -: INSN_W]), .opc(left_opc), .adr(left_adr));

  insn_fields #(.OPC_W(OPC_W), .ADR_W(ADR_W)) i_buf (
    .insn(ibr), .opc(buf_opc), .adr(buf_adr));

  opcode_decode #(.OPC_W(OPC_W)) i_dec (.opc(ir), .kind(kind));

  acc_alu #(.DATA_W(DATA_W)) i_alu (
    .acc(acc), .operand(mbr), .add_en(kind == K_ADD), .result(alu_out));

  assign addr_ok = (mar < LIM_ADR);
  assign pc_next = (pc == LAST_ADR) ? '0 : pc + 1'b1;
  assign op_read = (state == ST_EXEC) && addr_ok && (kind == K_LOAD || kind == K_ADD);

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = (state == ST_FETCH_R) || op_read;
  assign mem_wr    = (state == ST_ST_W);
  assign halted    = (state == ST_HALT);
  assign pc_out    = pc;
  assign acc_out   = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH_A;
      pc       <= ADR_W'(RESET_PC);
      mar      <= '0;
      mbr      <= '0;
      acc      <= '0;
      ir       <= '0;
      ibr      <= '0;
      ibr_full <= 1'b0;
    end else begin
      case (state)
        ST_FETCH_A: begin
          mar   <= pc;
          state <= ST_FETCH_R;
        end
        ST_FETCH_R: state <= ST_FETCH_W;
        ST_FETCH_W: begin
          mbr   <= mem_rdata;
          state <= ST_SPLIT;
        end
        ST_SPLIT: begin
          ir       <= left_opc;
          mar      <= left_adr;
          ibr      <= mbr[INSN_W-1:0];
          ibr_full <= 1'b1;
          pc       <= pc_next;
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!addr_ok || kind == K_HALT) begin
            state <= ST_HALT;
          end else begin
            case (kind)
              K_LOAD, K_ADD: state <= ST_OP_W;
              K_STORE: begin
                mbr   <= acc;
                state <= ST_ST_W;
              end
              default: begin // jump
                pc       <= mar;
                ibr_full <= 1'b0;
                state    <= ST_FETCH_A;
              end
            endcase
          end
        end
        ST_OP_W: begin
          mbr   <= mem_rdata;
          state <= ST_OP_X;
        end
        ST_OP_X: begin
          acc   <= alu_out;
          state <= ST_NEXT;
        end
        ST_ST_W: state <= ST_NEXT;
        ST_NEXT: begin
          if (ibr_full) begin
            ir       <= buf_opc;
            mar      <= buf_adr;
            ibr_full <= 1'b0;
            state    <= ST_EXEC;
          end else begin
            state <= ST_FETCH_A;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/pair_seq_checker.sv
`timescale 1ns/1ps
module pair_seq_checker #(
  parameter int ADR_W      = 12,
  parameter int ADDR_LIMIT = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [ADR_W-1:0] mem_addr,
  input logic             halted,
  input logic [ADR_W-1:0] pc_out
);
  p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_read_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  p_addr_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr < ADR_W'(ADDR_LIMIT)));
  p_pc_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out < ADR_W'(ADDR_LIMIT));
endmodule

bind pair_fetch_seq pair_seq_checker #(.ADR_W(ADR_W), .ADDR_LIMIT(ADDR_LIMIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .halted(halted), .pc_out(pc_out));

// File: tb/test_pair_fetch_seq.sv
`timescale 1ns/1ps
module test_pair_fetch_seq;
  localparam logic [7:0] C_LOAD = 8'h01, C_ADD = 8'h05, C_STORE = 8'h21,
                         C_JUMP = 8'h0D, C_HALT = 8'h00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [39:0] mem_wdata, mem_rdata, acc_out;
  logic [11:0] pc_out;

  logic [39:0] mem [0:1023];
  int n_rd, n_wr, n_both, n_rr;
  logic prev_rd;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pair_fetch_seq i_pair_fetch_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .pc_out(pc_out), .acc_out(acc_out));

  // synchronous RAM, one cycle read latency, plus access counters
  always @(posedge clk) begin
    if (!rst_n) begin
      n_rd <= 0; n_wr <= 0; n_both <= 0; n_rr <= 0; prev_rd <= 1'b0;
    end else begin
      if (mem_rd) begin
        n_rd <= n_rd + 1;
        mem_rdata <= (mem_addr < 12'd1024) ? mem[mem_addr[9:0]] : '0;
      end
      if (mem_wr) begin
        n_wr <= n_wr + 1;
        if (mem_addr < 12'd1024) mem[mem_addr[9:0]] <= mem_wdata;
      end
      if (mem_rd && mem_wr) n_both <= n_both + 1;
      if (mem_rd && prev_rd) n_rr <= n_rr + 1;
      prev_rd <= mem_rd;
    end
  end

  function automatic logic [19:0] ins(logic [7:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_and_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_and_run(input string tag);
    int t;
    rst_n = 1'b1;
    t = 0;
    while (!halted && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check({tag, " halted"}, 64'(halted), 64'd1);
  endtask

  task automatic t_reset();
    int t;
    clear_and_reset();
    mem[0] = {ins(C_HALT, 12'd0), ins(C_HALT, 12'd0)};
    check("R1 pc in reset", 64'(pc_out), 64'd0);
    check("R1 acc in reset", 64'(acc_out), 64'd0);
    check("R1 halted in reset", 64'(halted), 64'd0);
    check("R1 no read in reset", 64'(mem_rd), 64'd0);
    rst_n = 1'b1;
    t = 0;
    while (!mem_rd && t < 20) begin
      @(negedge clk);
      t++;
    end
    check("R1 first read strobe", 64'(mem_rd), 64'd1);
    check("R1 first read address", 64'(mem_addr), 64'd0);
  endtask

  task automatic t_basic();
    clear_and_reset();
    mem[0]  = {ins(C_LOAD, 12'd10), ins(C_ADD, 12'd11)};
    mem[1]  = {ins(C_STORE, 12'd12), ins(C_HALT, 12'd0)};
    mem[10] = 40'd5;
    mem[11] = 40'd7;
    release_and_run("R5");
    check("R6 acc after load+add", 64'(acc_out), 64'd12);
    check("R7 stored word", 64'(mem[12]), 64'd12);
    check("R3 read count", 64'(n_rd), 64'd4);
    check("R7 write count", 64'(n_wr), 64'd1);
    check("R4 pc after two words", 64'(pc_out), 64'd2);
  endtask

  task automatic t_order();
    clear_and_reset();
    mem[0]  = {ins(C_LOAD, 12'd20), ins(C_LOAD, 12'd21)};
    mem[1]  = {ins(C_HALT, 12'd0), ins(C_LOAD, 12'd20)};
    mem[20] = 40'h11;
    mem[21] = 40'h22;
    release_and_run("R2");
    check("R2 right half runs last", 64'(acc_out), 64'h22);
    check("R2 left half of word 1 halts", 64'(n_rd), 64'd4);
  endtask

  task automatic t_wrap_add();
    clear_and_reset();
    mem[0]  = {ins(C_LOAD, 12'd10), ins(C_ADD, 12'd11)};
    mem[1]  = {ins(C_HALT, 12'd0), ins(C_HALT, 12'd0)};
    mem[10] = 40'hFF_FFFF_FFFF;
    mem[11] = 40'd3;
    release_and_run("R6");
    check("R6 modulo sum", 64'(acc_out), 64'd2);
  endtask

  task automatic t_jump();
    clear_and_reset();
    mem[0]  = {ins(C_JUMP, 12'd5), ins(C_LOAD, 12'd31)};
    mem[5]  = {ins(C_ADD, 12'd30), ins(C_HALT, 12'd0)};
    mem[30] = 40'd42;
    mem[31] = 40'd99;
    release_and_run("R8");
    check("R8 pending right half dropped", 64'(acc_out), 64'd42);
    check("R8 pc after target word", 64'(pc_out), 64'd6);
    check("R8 read count", 64'(n_rd), 64'd3);
  endtask

  task automatic t_pc_wrap();
    logic [39:0] w;
    clear_and_reset();
    w = {ins(C_ADD, 12'd31), ins(C_HALT, 12'd0)};
    mem[0]   = {ins(C_JUMP, 12'd999), ins(C_HALT, 12'd0)};
    mem[999] = {ins(C_LOAD, 12'd30), ins(C_STORE, 12'd0)};
    mem[30]  = w;
    mem[31]  = 40'd1;
    release_and_run("R4");
    check("R4 word at 0 refetched after 999", 64'(acc_out), 64'(w + 40'd1));
    check("R4 pc wrapped then advanced", 64'(pc_out), 64'd1);
  endtask

  task automatic t_unknown();
    int r;
    clear_and_reset();
    mem[0]  = {ins(C_LOAD, 12'd30), ins(8'h7F, 12'd0)};
    mem[1]  = {ins(C_STORE, 12'd40), ins(C_HALT, 12'd0)};
    mem[30] = 40'd9;
    release_and_run("R9");
    r = n_rd;
    repeat (20) @(negedge clk);
    check("R9 stays halted", 64'(halted), 64'd1);
    check("R9 no reads after halt", 64'(n_rd), 64'(r));
    check("R9 no write after unknown opcode", 64'(n_wr), 64'd0);
    check("R9 acc kept", 64'(acc_out), 64'd9);
    check("R9 pc not advanced", 64'(pc_out), 64'd1);
  endtask

  task automatic t_range();
    clear_and_reset();
    mem[0]  = {ins(C_LOAD, 12'd30), ins(C_ADD, 12'd1000)};
    mem[30] = 40'd7;
    release_and_run("R10");
    check("R10 acc unchanged", 64'(acc_out), 64'd7);
    check("R10 no operand read", 64'(n_rd), 64'd2);
    clear_and_reset();
    mem[0] = {ins(C_JUMP, 12'd1023), ins(C_LOAD, 12'd0)};
    release_and_run("R10 jump");
    check("R10 jump out of range keeps pc", 64'(pc_out), 64'd1);
    check("R10 no fetch after bad jump", 64'(n_rd), 64'd1);
    check("R11 no read with write", 64'(n_both), 64'd0);
    check("R11 no back-to-back reads", 64'(n_rr), 64'd0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_wrap_add();
    t_jump();
    t_pc_wrap();
    t_unknown();
    t_range();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule